// File: doc/BRIEF.md
# Byte-Lane Register Hub: One Initiator, Eight Targets

This block joins a single bus initiator to eight identical register-bank targets over a synchronous, Wishbone-style handshake. The data path is 16 bits wide and is split into two byte lanes. The top three bits of the initiator address choose the target. The remaining low address bits choose a register inside that target. Only the chosen target sees the strobe. Write enable, lane selects, address and write data go to every target at once. Read data and acknowledge come back only from the target that answered.

Each target holds a small bank of 16-bit registers. Two lane-select bits control each access: bit 0 enables bits 7:0 and bit 1 enables bits 15:8. With both bits set, the whole word moves in one cycle. A small system-control stage forwards the shared clock and registers an active-high reset request into the synchronous reset used by every target.

Top module: `reg_hub8`

## Requirements
- R1: While reset is active, the acknowledge output stays low. After reset every register in every target reads as zero. The reset request takes effect one clock after it is applied.
- R2: Address bits [ADDR_W-1:ADDR_W-3] select the target. Code 0 selects target 0, code 1 selects target 1, and so on up to code 7. A write to one target leaves the same register offset in every other target unchanged.
- R3: With lane selects 2'b11, a write stores all 16 bits and a read returns all 16 bits.
- R4: With lane selects 2'b01, a write updates bits 7:0 only, and bits 15:8 of the register keep their earlier value.
- R5: With lane selects 2'b10, a write updates bits 15:8 only, and bits 7:0 keep their earlier value.
- R6: On a read, any byte lane whose select bit is low returns zero.
- R7: The acknowledge goes high in the clock after the target first sees CYC and STB together, and it stays high for exactly one clock.
- R8: An access with lane selects 2'b00 is still acknowledged, but it changes no register.
- R9: At most one target strobe is active at any time, and a target strobe is active only while the initiator drives both CYC and STB.
- R10: Read data appears on the initiator data output in the same cycle as the acknowledge. With no access in progress, the acknowledge stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_req_i | input | 1 | Active-high reset request, registered before use |
| m_cyc_i | input | 1 | Initiator cycle-valid |
| m_stb_i | input | 1 | Initiator strobe |
| m_we_i | input | 1 | Initiator write enable (1 = write) |
| m_sel_i | input | 2 | Byte-lane selects; bit 0 = bits 7:0, bit 1 = bits 15:8 |
| m_adr_i | input | ADDR_W (6) | Target code in the top 3 bits; register index in the low bits |
| m_dat_i | input | 16 | Write data |
| m_dat_o | output | 16 | Read data, valid with acknowledge |
| m_ack_o | output | 1 | One-clock acknowledge from the addressed target |

## Verification
Word, low-lane and high-lane writes are mixed on the same register, so a lane that leaks or is lost shows up as a value that differs from the bench model. Reads use every lane pattern, so stray bits on a lane that was not selected can be told apart from real data. The same offset is written in all eight targets with distinct values, which separates a wrong target decode from a wrong register index. An access with no lanes selected, a check with no access in progress, and a second reset after the banks are full cover the paths where nothing should change.

// File: rtl/reg_hub_pkg.sv
package reg_hub_pkg;
  // width of one byte lane, shared by every block of the hub
  localparam int unsigned LANE_W = 8;

  // number of lanes for a given data width
  function automatic int unsigned lanes_of(input int unsigned data_w);
    return data_w / LANE_W;
  endfunction
endpackage

// File: rtl/reg_hub_sysctl.sv
module reg_hub_sysctl (
  input  logic clk_i,
  input  logic rst_req_i,
  output logic clk_o,
  output logic rst_o
);
  // clock is forwarded; reset request is registered into a synchronous reset
  assign clk_o = clk_i;

  always_ff @(posedge clk_i) begin
    rst_o <= rst_req_i;
  end
endmodule

// File: rtl/reg_hub_bank.sv
module reg_hub_bank
  import reg_hub_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned REG_AW = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cyc,
  input  logic                          stb,
  input  logic                          we,
  input  logic [lanes_of(DATA_W)-1:0]   sel,
  input  logic [REG_AW-1:0]             adr,
  input  logic [DATA_W-1:0]             wdat,
  output logic [DATA_W-1:0]             rdat,
  output logic                          ack
);
  localparam int unsigned LANES = lanes_of(DATA_W);
  localparam int unsigned DEPTH = 1 << REG_AW;

  logic [DEPTH-1:0][DATA_W-1:0] regs;
  logic [DATA_W-1:0]            lmask;
  logic                         hit;

  // expand lane selects into a bit mask
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lmask[l*LANE_W +: LANE_W] = {LANE_W{sel[l]}};
  end

  // new request: strobe seen and not already answered
  assign hit = cyc & stb & ~ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      regs <= '0;
      ack  <= 1'b0;
      rdat <= '0;
    end else begin
      ack <= hit;
      if (hit && we) begin
        regs[adr] <= (regs[adr] & ~lmask) | (wdat & lmask);
      end
      rdat <= (hit && !we) ? (regs[adr] & lmask) : '0;
    end
  end

  // R7: acknowledge lasts one clock
  p_ack_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);

  // R7: acknowledge only follows a request seen one clock earlier
  p_ack_follows_req_r7: assert property (@(posedge clk) disable iff (rst)
    ack |-> $past(cyc && stb));

  // R8: an access with no lanes selected leaves the bank untouched
  p_nolane_keep_r8: assert property (@(posedge clk) disable iff (rst)
    (hit && we && (sel == '0)) |=> $stable(regs));

  // R1: bank clear and acknowledge low right after reset
  p_rst_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> ((regs == '0) && !ack));
endmodule

// File: rtl/reg_hub_xbar.sv
module reg_hub_xbar
  import reg_hub_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned SLV_BITS = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          m_cyc,
  input  logic                          m_stb,
  input  logic [SLV_BITS-1:0]           slv_code,
  output logic [DATA_W-1:0]             m_dat,
  output logic                          m_ack,
  output logic [(1<<SLV_BITS)-1:0]      s_stb,
  input  logic [(1<<SLV_BITS)-1:0][DATA_W-1:0] s_rdat,
  input  logic [(1<<SLV_BITS)-1:0]      s_ack
);
  localparam int unsigned NSLV = 1 << SLV_BITS;

  // strobe steering: one decoder output per target
  for (genvar k = 0; k < NSLV; k++) begin : g_dec
    assign s_stb[k] = m_cyc & m_stb & (slv_code == SLV_BITS'(k));
  end

  // return path keyed on which target acknowledged
  always_comb begin
    m_ack = 1'b0;
    m_dat = '0;
    for (int k = 0; k < NSLV; k++) begin
      if (s_ack[k]) begin
        m_ack = 1'b1;
        m_dat = m_dat | s_rdat[k];
      end
    end
  end

  // R9: never more than one target strobed
  p_stb_onehot_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(s_stb));

  // R9: a target strobe only during an initiator request
  p_stb_needs_req_r9: assert property (@(posedge clk) disable iff (rst)
    (|s_stb) |-> (m_cyc && m_stb));

  // R7: at most one target answers in any cycle
  p_ack_onehot_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(s_ack));
endmodule

// File: rtl/reg_hub8.sv
module reg_hub8
  import reg_hub_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned SLV_BITS = 3,
  parameter int unsigned REG_AW   = 3,
  localparam int unsigned ADDR_W  = SLV_BITS + REG_AW,
  localparam int unsigned LANES   = DATA_W / LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_req_i,
  input  logic              m_cyc_i,
  input  logic              m_stb_i,
  input  logic              m_we_i,
  input  logic [LANES-1:0]  m_sel_i,
  input  logic [ADDR_W-1:0] m_adr_i,
  input  logic [DATA_W-1:0] m_dat_i,
  output logic [DATA_W-1:0] m_dat_o,
  output logic              m_ack_o
);
  localparam int unsigned NSLV = 1 << SLV_BITS;

  logic clk;
  logic rst;
  logic [NSLV-1:0]             s_stb;
  logic [NSLV-1:0]             s_ack;
  logic [NSLV-1:0][DATA_W-1:0] s_rdat;

  reg_hub_sysctl u_sysctl (
    .clk_i     (clk_i),
    .rst_req_i (rst_req_i),
    .clk_o     (clk),
    .rst_o     (rst)
  );

  reg_hub_xbar #(
    .DATA_W   (DATA_W),
    .SLV_BITS (SLV_BITS)
  ) u_xbar (
    .clk      (clk),
    .rst      (rst),
    .m_cyc    (m_cyc_i),
    .m_stb    (m_stb_i),
    .slv_code (m_adr_i[ADDR_W-1 -: SLV_BITS]),
    .m_dat    (m_dat_o),
    .m_ack    (m_ack_o),
    .s_stb    (s_stb),
    .s_rdat   (s_rdat),
    .s_ack    (s_ack)
  );

  for (genvar k = 0; k < NSLV; k++) begin : g_bank
    reg_hub_bank #(
      .DATA_W (DATA_W),
      .REG_AW (REG_AW)
    ) u_bank (
      .clk  (clk),
      .rst  (rst),
      .cyc  (m_cyc_i),
      .stb  (s_stb[k]),
      .we   (m_we_i),
      .sel  (m_sel_i),
      .adr  (m_adr_i[REG_AW-1:0]),
      .wdat (m_dat_i),
      .rdat (s_rdat[k]),
      .ack  (s_ack[k])
    );
  end

  // R10: no acknowledge without an initiator request one clock earlier
  p_ack_needs_req_r10: assert property (@(posedge clk) disable iff (rst)
    m_ack_o |-> $past(m_cyc_i && m_stb_i));
endmodule

// File: tb/reg_hub8_tb.sv
module reg_hub8_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 6;

  logic        clk = 1'b0;
  logic        rst_req = 1'b1;
  logic        cyc = 1'b0, stb = 1'b0, we = 1'b0;
  logic [1:0]  sel = 2'b00;
  logic [ADDR_W-1:0] adr = '0;
  logic [15:0] wdat = '0;
  logic [15:0] rdat_o;
  logic        ack_o;

  int checks = 0;
  int failures = 0;
  logic [15:0] model [0:63];

  always #(CLK_PERIOD/2) clk = ~clk;

  reg_hub8 u_dut (
    .clk_i(clk), .rst_req_i(rst_req),
    .m_cyc_i(cyc), .m_stb_i(stb), .m_we_i(we), .m_sel_i(sel),
    .m_adr_i(adr), .m_dat_i(wdat), .m_dat_o(rdat_o), .m_ack_o(ack_o)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] lmask(input logic [1:0] s);
    return {{8{s[1]}}, {8{s[0]}}};
  endfunction

  // one access; checks ack latency (R7) and pulse width, returns read data
  task automatic xfer(input logic w, input logic [1:0] s, input logic [5:0] a,
                      input logic [15:0] d, output logic [15:0] r);
    @(negedge clk);
    cyc = 1'b1; stb = 1'b1; we = w; sel = s; adr = a; wdat = d;
    @(posedge clk); #1;
    check("R7 ack one clock after request", {15'd0, ack_o}, 16'd1);
    r = rdat_o;
    @(negedge clk);
    cyc = 1'b0; stb = 1'b0; we = 1'b0; sel = 2'b00; wdat = '0;
    @(posedge clk); #1;
    check("R7 ack single clock", {15'd0, ack_o}, 16'd0);
    if (w) model[a] = (model[a] & ~lmask(s)) | (d & lmask(s));
  endtask

  task automatic wr(input logic [1:0] s, input logic [5:0] a, input logic [15:0] d);
    logic [15:0] r;
    xfer(1'b1, s, a, d, r);
  endtask

  task automatic rd_check(input string req, input logic [1:0] s, input logic [5:0] a);
    logic [15:0] r;
    xfer(1'b0, s, a, 16'h0, r);
    check(req, r, model[a] & lmask(s));
  endtask

  task automatic t_reset();
    rst_req = 1'b1;
    repeat (4) begin
      @(negedge clk);
      check("R1 ack low in reset", {15'd0, ack_o}, 16'd0);
    end
    rst_req = 1'b0;
    @(posedge clk);
    for (int i = 0; i < 64; i++) model[i] = 16'h0;
    rd_check("R1 cleared slave0 reg0", 2'b11, 6'd0);
    rd_check("R1 cleared slave7 reg7", 2'b11, 6'd63);
    rd_check("R1 cleared slave3 reg5", 2'b11, 6'd29);
  endtask

  task automatic t_word();
    wr(2'b11, 6'd9, 16'hA5C3);
    rd_check("R3 word read", 2'b11, 6'd9);
    wr(2'b11, 6'd9, 16'h0F0F);
    rd_check("R3 word overwrite", 2'b11, 6'd9);
  endtask

  task automatic t_low();
    wr(2'b11, 6'd18, 16'h1234);
    wr(2'b01, 6'd18, 16'hFFAB);
    rd_check("R4 low byte written high kept", 2'b11, 6'd18);
    check("R4 model value", model[18], 16'h12AB);
  endtask

  task automatic t_high();
    wr(2'b11, 6'd27, 16'h5678);
    wr(2'b10, 6'd27, 16'hCDFF);
    rd_check("R5 high byte written low kept", 2'b11, 6'd27);
    check("R5 model value", model[27], 16'hCD78);
  endtask

  task automatic t_read_lanes();
    wr(2'b11, 6'd36, 16'hBEEF);
    rd_check("R6 low lane read upper zero", 2'b01, 6'd36);
    rd_check("R6 high lane read lower zero", 2'b10, 6'd36);
    rd_check("R6 no lane read all zero", 2'b00, 6'd36);
  endtask

  task automatic t_nolane();
    wr(2'b11, 6'd45, 16'h3C3C);
    wr(2'b00, 6'd45, 16'hFFFF);
    rd_check("R8 no-lane write leaves register", 2'b11, 6'd45);
  endtask

  task automatic t_decode();
    for (int k = 0; k < 8; k++) wr(2'b11, 6'(k*8 + 2), 16'h1100 + 16'(k * 17));
    for (int k = 0; k < 8; k++) rd_check("R2 target decode isolation", 2'b11, 6'(k*8 + 2));
    wr(2'b11, 6'd5, 16'h7777);
    rd_check("R2 neighbour target untouched", 2'b11, 6'd13);
    rd_check("R2 same offset other target", 2'b11, 6'd61);
  endtask

  task automatic t_idle();
    logic [15:0] r;
    repeat (3) begin
      @(negedge clk);
      check("R10 no ack while idle", {15'd0, ack_o}, 16'd0);
    end
    // stb without cyc must not be answered
    @(negedge clk); stb = 1'b1; adr = 6'd9;
    @(posedge clk); #1;
    check("R9 strobe without cycle ignored", {15'd0, ack_o}, 16'd0);
    @(negedge clk); stb = 1'b0;
    xfer(1'b0, 2'b11, 6'd9, 16'h0, r);
    check("R10 data valid with ack", r, model[9]);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_word();
    t_low();
    t_high();
    t_read_lanes();
    t_nolane();
    t_decode();
    t_idle();
    t_reset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule